// File: doc/BRIEF.md
# ADC Conversion Request Sequencer

This controller sits on the host side of an external multichannel ADC that runs in its externally timed acquisition mode. A single `start` pulse, together with a conversion count, makes the controller issue one active-low conversion-start pulse per requested conversion. The low phase of each pulse is the acquisition window. The controller times it in system clock cycles. Its length depends on the reference mode and on whether a temperature reading is wanted, and both are sampled again at the start of every request.

After each rising edge the controller waits until the ADC's active-low end-of-conversion line, passed through a synchronizer, has gone high and then low. Only then does it start the next acquisition. When the last conversion of the sequence has finished, it raises `fifo_ready` so that the host may read the ADC's FIFO. If end-of-conversion never arrives, a timeout raises `timeout_err` and the controller returns to idle. Chip-select is kept high for the whole sequence, so the conversion-start line alone re-arms end-of-conversion.

Top module: `conv_req_seq`

## Requirements
- R1: After synchronous reset, `cnvst_n` and `cs_n` are high and `busy`, `fifo_ready` and `timeout_err` are low.
- R2: An accepted start produces exactly `conv_count` low pulses on `cnvst_n`, for any count from 1 up to 514.
- R3: With `ref_mode` set to 2'b01 or 2'b11 and `temp_req` low, each low phase lasts ceil(1400 ns × CLK_HZ / 1e9) cycles, which is 70 cycles at 50 MHz.
- R4: With `ref_mode` set to 2'b00 or 2'b10 and `temp_req` low, each low phase is lengthened by the reference wake time to ceil(46400 ns × CLK_HZ / 1e9) cycles, which is 2320 cycles at 50 MHz.
- R5: With `temp_req` high, each low phase lasts ceil(40 ns × CLK_HZ / 1e9) cycles (2 at 50 MHz), whatever `ref_mode` is.
- R6: Within a sequence, `cnvst_n` falls for a new request only after the synchronized `eoc_n` has been seen high and then low since the previous rising edge. `cs_n` never goes low.
- R7: `busy` rises on the cycle after an accepted start and falls when the last conversion completes. A start is ignored while `busy` is high and whenever `conv_count` is 0.
- R8: `fifo_ready` rises only when the final conversion of a sequence completes, is never high together with `busy`, and clears on the next accepted start.
- R9: If `eoc_n` has not completed its handshake within TIMEOUT_CYC cycles of a rising edge, `timeout_err` is set, `busy` drops with `fifo_ready` low, and the next accepted start clears the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a sequence (taken only when idle) |
| conv_count | input | CNT_W | Number of conversions to request |
| ref_mode | input | 2 | Reference mode code; bit 0 low means the internal reference must wake |
| temp_req | input | 1 | Temperature measurement requested (short low phase) |
| eoc_n | input | 1 | Asynchronous active-low end-of-conversion from the ADC |
| cnvst_n | output | 1 | Active-low conversion-start to the ADC |
| cs_n | output | 1 | Active-low chip-select, held high |
| busy | output | 1 | Sequence in progress |
| fifo_ready | output | 1 | All requested conversions complete |
| timeout_err | output | 1 | End-of-conversion did not arrive in time |

## Verification
On every cycle, the assertions check four things: a repeated conversion-start fall is preceded by a low synchronized end-of-conversion; the start line is never low outside `busy`; `fifo_ready` and `busy` are never high together; and a timeout always leaves the controller idle with the start line released. The exact low-phase lengths for each reference and temperature setting, the pulse count up to 514, the gap that a slow ADC forces between pulses, and the ignoring of starts while busy or with a zero count can only be shown by the bench scenarios. In those scenarios an ADC model answers each rising edge after a programmable delay or not at all.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_CONV = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [1:0] ref_mode;
        logic       temp;
    } req_cfg_t;

    // Round a duration in ns up to whole clock cycles.
    function automatic int unsigned ns_to_cycles(longint unsigned ns, longint unsigned hz);
        longint unsigned c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        return int'(c);
    endfunction

    // Reference codes with bit 0 clear need the internal reference to wake.
    function automatic logic needs_ref_wake(logic [1:0] mode);
        return !mode[0];
    endfunction

endpackage

// File: rtl/eoc_sync.sv
module eoc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/low_timer.sv
module low_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;
    logic         active;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (load) begin
            cnt    <= load_val;
            active <= 1'b1;
        end else if (active) begin
            if (cnt == '0) active <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end

    assign expired = active && (cnt == '0);
endmodule

// File: rtl/eoc_waiter.sv
module eoc_waiter #(
    parameter int TIMEOUT_CYC = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic eoc_s,
    output logic complete,
    output logic timed_out
);
    localparam int TO_W = $clog2(TIMEOUT_CYC + 1);

    logic            armed;
    logic [TO_W-1:0] tcnt;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            armed <= 1'b0;
            tcnt  <= '0;
        end else begin
            if (eoc_s) armed <= 1'b1;
            if (tcnt != TO_W'(TIMEOUT_CYC - 1)) tcnt <= tcnt + 1'b1;
        end
    end

    assign complete  = enable && armed && !eoc_s;
    assign timed_out = enable && !complete && (tcnt == TO_W'(TIMEOUT_CYC - 1));
endmodule

// File: rtl/conv_req_seq.sv
module conv_req_seq
    import conv_seq_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int ACQ_NS      = 1400,
    parameter int REF_WAKE_NS = 45000,
    parameter int TEMP_ACQ_NS = 40,
    parameter int TIMEOUT_CYC = 4096,
    parameter int CNT_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] conv_count,
    input  logic [1:0]       ref_mode,
    input  logic             temp_req,
    input  logic             eoc_n,
    output logic             cnvst_n,
    output logic             cs_n,
    output logic             busy,
    output logic             fifo_ready,
    output logic             timeout_err
);
    localparam int unsigned ACQ_CYC  = ns_to_cycles(ACQ_NS, CLK_HZ);
    localparam int unsigned WAKE_CYC = ns_to_cycles(ACQ_NS + REF_WAKE_NS, CLK_HZ);
    localparam int unsigned TEMP_CYC = ns_to_cycles(TEMP_ACQ_NS, CLK_HZ);
    localparam int unsigned MAX_CYC  = (WAKE_CYC > ACQ_CYC) ? WAKE_CYC : ACQ_CYC;
    localparam int          LOW_W    = $clog2(MAX_CYC + 1);

    seq_state_e       state;
    logic [CNT_W-1:0] remaining;
    req_cfg_t         cfg;
    logic [LOW_W-1:0] low_sel;
    logic             eoc_s, acq_done, eoc_done, eoc_late;
    logic             accept, next_req, timer_load;

    assign cs_n = 1'b1;
    assign cfg  = '{ref_mode: ref_mode, temp: temp_req};

    always_comb begin
        if (cfg.temp)                       low_sel = LOW_W'(TEMP_CYC - 1);
        else if (needs_ref_wake(cfg.ref_mode)) low_sel = LOW_W'(WAKE_CYC - 1);
        else                                low_sel = LOW_W'(ACQ_CYC - 1);
    end

    assign accept     = (state == ST_IDLE) && start && (conv_count != '0);
    assign next_req   = (state == ST_CONV) && eoc_done && (remaining != CNT_W'(1));
    assign timer_load = accept || next_req;

    eoc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(eoc_n), .sync_out(eoc_s)
    );

    low_timer #(.W(LOW_W)) u_timer (
        .clk(clk), .rst(rst), .load(timer_load), .load_val(low_sel), .expired(acq_done)
    );

    eoc_waiter #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wait (
        .clk(clk), .rst(rst), .enable(state == ST_CONV), .eoc_s(eoc_s),
        .complete(eoc_done), .timed_out(eoc_late)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cnvst_n     <= 1'b1;
            busy        <= 1'b0;
            fifo_ready  <= 1'b0;
            timeout_err <= 1'b0;
            remaining   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    state       <= ST_ACQ;
                    cnvst_n     <= 1'b0;
                    busy        <= 1'b1;
                    fifo_ready  <= 1'b0;
                    timeout_err <= 1'b0;
                    remaining   <= conv_count;
                end
                ST_ACQ: if (acq_done) begin
                    state   <= ST_CONV;
                    cnvst_n <= 1'b1;
                end
                ST_CONV: begin
                    if (eoc_done) begin
                        if (remaining == CNT_W'(1)) begin
                            state      <= ST_IDLE;
                            busy       <= 1'b0;
                            fifo_ready <= 1'b1;
                        end else begin
                            state     <= ST_ACQ;
                            cnvst_n   <= 1'b0;
                            remaining <= remaining - 1'b1;
                        end
                    end else if (eoc_late) begin
                        state       <= ST_IDLE;
                        busy        <= 1'b0;
                        timeout_err <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6
    eoc_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(cnvst_n) && $past(state) == ST_CONV) |-> $past(!eoc_s));

    // R7
    start_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !cnvst_n |-> busy);

    // R8
    fifo_idle_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_ready |-> !busy);

    // R9
    timeout_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_err) |-> (!busy && !fifo_ready && cnvst_n));
endmodule

// File: tb/conv_req_seq_tb.sv
module conv_req_seq_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [9:0] conv_count = '0;
    logic [1:0] ref_mode = 2'b01;
    logic       temp_req = 1'b0;
    logic       eoc_n = 1'b1;
    logic       cnvst_n, cs_n, busy, fifo_ready, timeout_err;

    int checks = 0, fails = 0, cyc = 0;

    conv_req_seq u_dut (
        .clk(clk), .rst(rst), .start(start), .conv_count(conv_count),
        .ref_mode(ref_mode), .temp_req(temp_req), .eoc_n(eoc_n),
        .cnvst_n(cnvst_n), .cs_n(cs_n), .busy(busy),
        .fifo_ready(fifo_ready), .timeout_err(timeout_err)
    );

    always #10 clk = ~clk;

    // ADC model
    bit model_en = 0, adc_dead = 0;
    int conv_dly = 25;
    always @(negedge cnvst_n) if (model_en) eoc_n <= 1'b1;
    always @(posedge cnvst_n) begin
        if (model_en && !adc_dead) begin
            repeat (conv_dly) @(posedge clk);
            if (!adc_dead) eoc_n <= 1'b0;
        end
    end

    // Monitor
    int run = 0, hi_run = 0, pulses = 0, min_w = 0, max_w = 0, gate_viol = 0, min_gap = 0, cs_low = 0;
    bit first = 1, prev_cnv = 1, prev_eoc = 1;
    always @(negedge clk) begin
        cyc++;
        if (!cs_n) cs_low++;
        if (!cnvst_n) begin
            if (prev_cnv) begin
                if (!first && prev_eoc) gate_viol++;
                if (!first && (min_gap == 0 || hi_run < min_gap)) min_gap = hi_run;
                first = 0;
            end
            run++;
            hi_run = 0;
        end else begin
            if (!prev_cnv) begin
                pulses++;
                if (min_w == 0 || run < min_w) min_w = run;
                if (run > max_w) max_w = run;
                run = 0;
            end
            if (busy) hi_run++;
        end
        prev_cnv = cnvst_n;
        prev_eoc = eoc_n;
        if (cyc == 190000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        pulses = 0; min_w = 0; max_w = 0; gate_viol = 0; min_gap = 0; first = 1;
    endtask

    task automatic pulse_start(input int cnt);
        @(negedge clk);
        conv_count = 10'(cnt);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 60000 && busy; n++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(cnvst_n == 1'b1, "R1 cnvst_n", int'(cnvst_n), 1);
        chk(cs_n == 1'b1, "R1 cs_n", int'(cs_n), 1);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(fifo_ready == 1'b0, "R1 fifo_ready", int'(fifo_ready), 0);
        chk(timeout_err == 1'b0, "R1 timeout_err", int'(timeout_err), 0);
    endtask

    task automatic t_seq(input string req, input int cnt, input logic [1:0] mode,
                         input logic temp, input int expw);
        ref_mode = mode;
        temp_req = temp;
        clear_mon();
        pulse_start(cnt);
        chk(busy == 1'b1, "R7 busy after start", int'(busy), 1);
        chk(fifo_ready == 1'b0, "R8 fifo_ready cleared", int'(fifo_ready), 0);
        wait_idle();
        chk(pulses == cnt, "R2 pulse count", pulses, cnt);
        chk(min_w == expw, {req, " min low width"}, min_w, expw);
        chk(max_w == expw, {req, " max low width"}, max_w, expw);
        chk(gate_viol == 0, "R6 eoc handshake", gate_viol, 0);
        chk(cs_low == 0, "R6 cs_n held high", cs_low, 0);
        chk(fifo_ready == 1'b1, "R8 fifo_ready at end", int'(fifo_ready), 1);
        chk(timeout_err == 1'b0, "R9 no timeout", int'(timeout_err), 0);
    endtask

    task automatic t_busy_ignore();
        ref_mode = 2'b01; temp_req = 1'b0;
        clear_mon();
        pulse_start(3);
        repeat (10) @(negedge clk);
        pulse_start(7);
        wait_idle();
        chk(pulses == 3, "R7 start ignored while busy", pulses, 3);
    endtask

    task automatic t_zero();
        clear_mon();
        pulse_start(0);
        chk(busy == 1'b0, "R7 zero count busy", int'(busy), 0);
        repeat (6) @(negedge clk);
        chk(pulses == 0, "R7 zero count pulses", pulses, 0);
        chk(fifo_ready == 1'b1, "R8 fifo_ready kept on ignored start", int'(fifo_ready), 1);
    endtask

    task automatic t_slow();
        conv_dly = 300;
        t_seq("R3 slow", 3, 2'b11, 1'b0, 70);
        chk(min_gap > 300, "R6 gap follows eoc", min_gap, 301);
        conv_dly = 25;
    endtask

    task automatic t_timeout();
        adc_dead = 1;
        ref_mode = 2'b01; temp_req = 1'b0;
        clear_mon();
        pulse_start(2);
        wait_idle();
        chk(timeout_err == 1'b1, "R9 timeout flag", int'(timeout_err), 1);
        chk(busy == 1'b0, "R9 idle after timeout", int'(busy), 0);
        chk(fifo_ready == 1'b0, "R9 no fifo_ready", int'(fifo_ready), 0);
        chk(pulses == 1, "R9 stop after first pulse", pulses, 1);
        adc_dead = 0;
        pulse_start(1);
        chk(timeout_err == 1'b0, "R9 error cleared by start", int'(timeout_err), 0);
        wait_idle();
        chk(fifo_ready == 1'b1, "R9 recovery completes", int'(fifo_ready), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        model_en = 1;
        @(negedge clk);
        t_reset();
        t_seq("R3", 3, 2'b01, 1'b0, 70);
        t_seq("R3 mode11", 2, 2'b11, 1'b0, 70);
        t_seq("R4 mode00", 1, 2'b00, 1'b0, 2320);
        t_seq("R4 mode10", 2, 2'b10, 1'b0, 2320);
        t_seq("R5 mode00", 4, 2'b00, 1'b1, 2);
        t_seq("R5 mode01", 2, 2'b01, 1'b1, 2);
        t_busy_ignore();
        t_zero();
        t_slow();
        t_timeout();
        t_seq("R5 max count", 514, 2'b10, 1'b1, 2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule